// File: doc/BRIEF.md
# Burst-Two Double-Rate SRAM Emulator

This block is a synthesizable stand-in for a synchronous static RAM slave. It moves two data beats per command clock cycle, one on each half of the cycle. Both halves are modelled as consecutive edges of a single beat-rate clock. The `kphase` output tells the host which half comes next.

On a command beat, a low load strobe latches an address and a direction. Every command is a fixed two-word burst: the latched address first, then the address one above it, wrapping at the top of the memory. Write data arrives one full cycle after the command, one word per beat. Each word carries its own pair of active-low half-word write selects. Read data comes back on the output bus two and a half cycles after the command. A flag marks exactly the beats that carry read data. On every other beat the bus is parked at zero, which stands in for a high-impedance state.

A clock-enable input models a stopped clock. While it is low, every register holds its value and no beats are counted.

Top module: `burst2_sram`

## Requirements
- R1: Synchronous active-low reset, sampled on a clock edge, leaves `rdata_oe` at 0, `rdata` at 0 and `kphase` at 0. It also cancels any burst that is in flight.
- R2: A command is taken only on an enabled edge where `kphase` is 0 and `ld_n` is low. `rd_wr` high requests a read and low requests a write. A low `ld_n` on an edge where `kphase` is 1 does nothing.
- R3: A burst touches address A and then address (A+1) modulo 2^AW, so address all-ones is followed by address zero.
- R4: For a write command taken on enabled edge E, the word for A is sampled from `wdata` on enabled edge E+2. The word for A+1 is sampled on edge E+3.
- R5: For a read command taken on enabled edge E, `rdata` shows the word at A from enabled edge E+5 and the word at A+1 from edge E+6, with `rdata_oe` at 1 on both beats.
- R6: `wmask_n[0]` low writes `wdata[DW/2-1:0]` and `wmask_n[1]` low writes `wdata[DW-1:DW/2]`. A high select leaves that half unchanged, and both high writes nothing. The selects are sampled separately on each beat.
- R7: `rdata_oe` is 1 on exactly the read-data beats. Whenever it is 0, `rdata` is 0.
- R8: A command may be issued every cycle. A read returns every word written on beats before its own data beat, including a write issued in the cycle just before it.
- R9: While `en` is low, every register holds: `rdata`, `rdata_oe`, `kphase` and the burst timing all stay as they are.
- R10: `kphase` is 0 out of reset and toggles on every enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock; each edge is one half of a command cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable; low freezes all state |
| ld_n | input | 1 | Active-low command strobe |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| addr | input | AW | Burst start address |
| wdata | input | DW | Write data for the current beat |
| wmask_n | input | 2 | Active-low half-word write selects for the current beat |
| kphase | output | 1 | 0 when the next enabled edge can take a command |
| rdata | output | DW | Read data; zero when not enabled |
| rdata_oe | output | 1 | High on the beats that carry read data |

## Verification
All timing is counted in enabled edges from the command edge E. Write words are consumed at E+2 and E+3, and read words appear on the outputs just after E+5 and E+6. The bench drives inputs and samples outputs on the falling edge. It keeps a behavioural reference with a beat counter and a small schedule of pending beats, and compares `rdata`, `rdata_oe` and `kphase` with it after every edge. Directed tasks count falling edges from the command and check the exact beats at which the burst must be absent, present and gone again. Those checks cover the cycle-to-cycle write-then-read case and the stalled-clock case.

// File: rtl/burst2_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the burst-two SRAM emulator.
// Assumes: beat offsets below are fixed by the interface timing.
package burst2_pkg;
    // What a pipeline slot carries
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2
    } beat_op_e;

    // Beats from the command edge to the first data beat
    localparam int WR_LAG = 2;
    localparam int RD_LAG = 5;
endpackage

// File: rtl/burst2_seq.sv
`timescale 1ns/1ps
// Command sequencer: tracks the half-cycle phase, accepts commands on
// phase-0 beats, and delays each command through a beat-indexed shift line
// to raise the write and read beat strobes with the burst address.
// Assumes: commands are at least two beats apart (phase gating guarantees it).
module burst2_seq
    import burst2_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    output logic          ph,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr
);
    localparam int DEPTH = RD_LAG + 1;
    localparam int WA    = WR_LAG - 1;
    localparam int WB    = WR_LAG;
    localparam int RA    = RD_LAG - 1;
    localparam int RB    = RD_LAG;

    beat_op_e      st_op [DEPTH];
    logic [AW-1:0] st_ad [DEPTH];

    // Half-cycle phase toggle
    always_ff @(posedge clk) begin
        if (!rst_n)  ph <= 1'b0;
        else if (en) ph <= ~ph;
    end

    // Capture a command into slot 0 and shift the delay line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_op[i] <= OP_IDLE;
                st_ad[i] <= '0;
            end
        end else if (en) begin
            st_op[0] <= (!ph && !ld_n) ? (rd_wr ? OP_RD : OP_WR) : OP_IDLE;
            st_ad[0] <= addr;
            for (int i = 1; i < DEPTH; i++) begin
                st_op[i] <= st_op[i-1];
                st_ad[i] <= st_ad[i-1];
            end
        end
    end

    // Beat strobes and burst addresses (second beat uses A+1, wrapping)
    assign wr_go   = (st_op[WA] == OP_WR) || (st_op[WB] == OP_WR);
    assign wr_addr = (st_op[WA] == OP_WR) ? st_ad[WA] : st_ad[WB] + AW'(1);
    assign rd_go   = (st_op[RA] == OP_RD) || (st_op[RB] == OP_RD);
    assign rd_addr = (st_op[RA] == OP_RD) ? st_ad[RA] : st_ad[RB] + AW'(1);

    // R2: a command only lands in slot 0 from a phase-0 beat
    a_r2_cmd_on_k_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (st_op[0] != OP_IDLE) |-> ph);
    // R4: first write beat falls on a phase-0 edge
    a_r4_wr_first_on_k: assert property (@(posedge clk) disable iff (!rst_n)
        (st_op[WA] == OP_WR) |-> !ph);
    // R4: never two write bursts claiming the same beat
    a_r4_one_write_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_op[WA] == OP_WR) && (st_op[WB] == OP_WR)));
    // R5: first read word is launched on a half-cycle edge
    a_r5_rd_on_half: assert property (@(posedge clk) disable iff (!rst_n)
        (st_op[RA] == OP_RD) |-> ph);
endmodule

// File: rtl/burst2_store.sv
`timescale 1ns/1ps
// Storage array split into two half-word banks with independent active-low
// write selects, plus the registered read port and output-enable flag.
// Assumes: DW is even; memory contents are not reset.
module burst2_store #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    wmask_n,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);
    localparam int HW    = DW / 2;
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] rd_word;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HW-1:0] bank [WORDS];

        // Write this half when its select is low on a write beat
        always_ff @(posedge clk) begin
            if (en && wr_go && !wmask_n[h])
                bank[wr_addr] <= wdata[h*HW +: HW];
        end

        assign rd_word[h*HW +: HW] = bank[rd_addr];
    end

    // Register the read beat; park the bus at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else if (en) begin
            rdata    <= rd_go ? rd_word : '0;
            rdata_oe <= rd_go;
        end
    end

    // R7: an idle bus carries zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));
    // R9: a stalled clock holds the outputs
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(rdata) && $stable(rdata_oe)));
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
// Top of the burst-two double-rate SRAM emulator: joins the command
// sequencer and the half-word storage array.
// Assumes: both clock phases are presented as alternating beats of clk.
module burst2_sram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    wmask_n,
    output logic          kphase,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);
    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    burst2_seq #(.AW(AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ld_n    (ld_n),
        .rd_wr   (rd_wr),
        .addr    (addr),
        .ph      (kphase),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .rd_go   (rd_go),
        .rd_addr (rd_addr)
    );

    burst2_store #(.AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .wdata    (wdata),
        .wmask_n  (wmask_n),
        .rd_go    (rd_go),
        .rd_addr  (rd_addr),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );
endmodule

// File: tb/sim_burst2_sram.sv
`timescale 1ns/1ps
module sim_burst2_sram;
    localparam int AW = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic          ld_n = 1'b1;
    logic          rd_wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [1:0]    wmask_n = 2'b11;
    logic          kphase;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #2.5 clk = ~clk;

    burst2_sram #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_n(ld_n), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .wmask_n(wmask_n),
        .kphase(kphase), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill(int a);
        return DW'(a * 3 + 1);
    endfunction

    // Behavioural reference: beat counter plus an 8-slot schedule
    int            bc = 0;
    int            s;
    logic [DW-1:0] mm [1<<AW];
    bit            wv [8];
    bit            rv [8];
    logic [AW-1:0] wa [8];
    logic [AW-1:0] ra [8];
    logic          m_oe = 1'b0;
    logic [DW-1:0] m_q = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            bc = 0;
            for (int i = 0; i < 8; i++) begin wv[i] = 0; rv[i] = 0; end
            m_oe = 1'b0;
            m_q  = '0;
        end else if (en) begin
            s = bc % 8;
            if (rv[s]) begin
                m_oe = 1'b1; m_q = mm[ra[s]]; rv[s] = 0;
            end else begin
                m_oe = 1'b0; m_q = '0;
            end
            if (wv[s]) begin
                if (!wmask_n[0]) mm[wa[s]][DW/2-1:0]  = wdata[DW/2-1:0];
                if (!wmask_n[1]) mm[wa[s]][DW-1:DW/2] = wdata[DW-1:DW/2];
                wv[s] = 0;
            end
            if ((bc % 2) == 0 && !ld_n) begin
                if (rd_wr) begin
                    rv[(bc+5)%8] = 1; ra[(bc+5)%8] = addr;
                    rv[(bc+6)%8] = 1; ra[(bc+6)%8] = addr + AW'(1);
                end else begin
                    wv[(bc+2)%8] = 1; wa[(bc+2)%8] = addr;
                    wv[(bc+3)%8] = 1; wa[(bc+3)%8] = addr + AW'(1);
                end
            end
            bc = bc + 1;
        end
    end

    // Every-beat comparison against the reference (R5, R7, R10)
    always @(negedge clk) begin
        if (chk_on) begin
            check("R7 rdata_oe vs model", 32'(rdata_oe), 32'(m_oe));
            check("R5 rdata vs model", 32'(rdata), 32'(m_q));
            check("R10 kphase vs model", 32'(kphase), 32'(bc % 2));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic align();
        while (kphase !== 1'b0) step();
    endtask

    task automatic wr_burst(logic [AW-1:0] a, logic [DW-1:0] d0, logic [1:0] m0,
                            logic [DW-1:0] d1, logic [1:0] m1);
        align();
        ld_n = 1'b0; rd_wr = 1'b0; addr = a;
        step();
        ld_n = 1'b1;
        step();
        wdata = d0; wmask_n = m0;
        step();
        wdata = d1; wmask_n = m1;
        step();
        wmask_n = 2'b11;
    endtask

    task automatic rd_burst(logic [AW-1:0] a, logic [DW-1:0] e0, logic [DW-1:0] e1,
                            string tag);
        align();
        ld_n = 1'b0; rd_wr = 1'b1; addr = a;
        step();
        ld_n = 1'b1;
        repeat (4) step();
        check({tag, " R5 not yet"}, 32'(rdata_oe), 32'd0);
        step();
        check({tag, " R5 first oe"}, 32'(rdata_oe), 32'd1);
        check({tag, " R5 first word"}, 32'(rdata), 32'(e0));
        step();
        check({tag, " R5 second oe"}, 32'(rdata_oe), 32'd1);
        check({tag, " R5 second word"}, 32'(rdata), 32'(e1));
        step();
        check({tag, " R7 oe drops"}, 32'(rdata_oe), 32'd0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        check("R1 reset oe", 32'(rdata_oe), 32'd0);
        check("R1 reset rdata", 32'(rdata), 32'd0);
        check("R1 reset kphase", 32'(kphase), 32'd0);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // Preload every word (R4)
        for (int a = 0; a < (1 << AW); a += 2)
            wr_burst(AW'(a), fill(a), 2'b00, fill(a + 1), 2'b00);
        rd_burst(6'd6, fill(6), fill(7), "R4 preload");

        // R3: wrap from all-ones to zero
        wr_burst(6'd63, 8'h3C, 2'b00, 8'hC3, 2'b00);
        rd_burst(6'd63, 8'h3C, 8'hC3, "R3 wrap");
        rd_burst(6'd0, 8'hC3, fill(1), "R3 wrapped word at zero");

        // R6: per-beat half masks, and both-high writes nothing
        wr_burst(6'd10, 8'hF0, 2'b10, 8'h0F, 2'b01);
        rd_burst(6'd10, 8'h10, 8'h02, "R6 half masks");
        wr_burst(6'd20, 8'hAA, 2'b11, 8'h55, 2'b11);
        rd_burst(6'd20, fill(20), fill(21), "R6 no write");

        // R2: strobe on a phase-1 beat is ignored (read and write)
        align(); step();
        ld_n = 1'b0; rd_wr = 1'b1; addr = 6'd4;
        step();
        ld_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            check("R2 ignored read oe", 32'(rdata_oe), 32'd0);
        end
        align(); step();
        ld_n = 1'b0; rd_wr = 1'b0; addr = 6'd12;
        step();
        ld_n = 1'b1; wdata = 8'hEE; wmask_n = 2'b00;
        repeat (4) step();
        wmask_n = 2'b11;
        rd_burst(6'd12, fill(12), fill(13), "R2 ignored write");

        // R8: write then read of the same words one cycle later
        align();
        ld_n = 1'b0; rd_wr = 1'b0; addr = 6'd30;
        step();
        ld_n = 1'b1;
        step();
        ld_n = 1'b0; rd_wr = 1'b1; addr = 6'd30; wdata = 8'h77; wmask_n = 2'b00;
        step();
        ld_n = 1'b1; wdata = 8'h88;
        step();
        wmask_n = 2'b11;
        repeat (3) step();
        step();
        check("R8 raw first oe", 32'(rdata_oe), 32'd1);
        check("R8 raw first word", 32'(rdata), 32'h77);
        step();
        check("R8 raw second word", 32'(rdata), 32'h88);

        // R9: stall in the middle of a read burst
        align();
        ld_n = 1'b0; rd_wr = 1'b1; addr = 6'd40;
        step();
        ld_n = 1'b1;
        repeat (5) step();
        check("R9 before stall", 32'(rdata), 32'(fill(40)));
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R9 frozen oe", 32'(rdata_oe), 32'd1);
            check("R9 frozen rdata", 32'(rdata), 32'(fill(40)));
            check("R9 frozen kphase", 32'(kphase), 32'd0);
        end
        en = 1'b1;
        step();
        check("R9 resumed word", 32'(rdata), 32'(fill(41)));
        step();
        check("R9 burst ends", 32'(rdata_oe), 32'd0);

        // R1: reset during a read burst cancels it
        align();
        ld_n = 1'b0; rd_wr = 1'b1; addr = 6'd50;
        step();
        ld_n = 1'b1;
        repeat (5) step();
        check("R1 burst live", 32'(rdata), 32'(fill(50)));
        rst_n = 1'b0;
        step();
        check("R1 mid-burst reset oe", 32'(rdata_oe), 32'd0);
        check("R1 mid-burst reset rdata", 32'(rdata), 32'd0);
        check("R1 mid-burst reset kphase", 32'(kphase), 32'd0);
        rst_n = 1'b1;
        step();
        check("R1 no leftover beat", 32'(rdata_oe), 32'd0);
        rd_burst(6'd50, fill(50), fill(51), "R1 after reset");

        // R8: random traffic, commands possible every cycle, with stalls
        for (int i = 0; i < 1500; i++) begin
            en      = (($urandom % 8) != 0);
            ld_n    = 1'($urandom);
            rd_wr   = 1'($urandom);
            addr    = AW'($urandom);
            wdata   = DW'($urandom);
            wmask_n = 2'($urandom);
            step();
        end
        en = 1'b1; ld_n = 1'b1; wmask_n = 2'b11;
        repeat (12) step();
        finish_run();
    end
endmodule